// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-bus slave protocol engine and the array of a 4096-byte memory. The memory has 128 pages of 32 bytes. A write session opens with a page number and a starting byte offset. The engine then hands over data bytes one strobe at a time. Each byte lands at the current offset, and the offset advances. When it passes the last byte of the page it wraps to offset zero, so a long session overwrites bytes it loaded earlier. A per-offset valid mask records which positions hold loaded data.

When the engine sees STOP it pulses the commit strobe. The buffer then runs one write cycle of a programmable number of clocks. During that cycle it raises busy, which the engine uses to refuse acknowledges so that a bus master can poll for completion. The write port sends out only the masked bytes, in ascending offset order, one per clock at the start of the cycle.

A session rejected for write protection, or dropped for any other reason, is discarded through the drop input and never reaches the array. A commit with nothing loaded does not start a write cycle at all. The write-cycle length must be at least the page size.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy_o and mem_we_o are low.
- R2: A byte loaded at session offset k of page p is written to array address p*32+k, where the address is formed with the page in bits 11:5 and the offset in bits 4:0.
- R3: The load offset starts at sess_offs_i and advances by one per accepted byte. After offset 31 it returns to 0. A later byte at the same offset replaces the earlier one, so only the last value is written.
- R4: During a write cycle, the byte at offset k is presented on the write port in busy cycle k (the first busy cycle is cycle 0), and only if that offset was loaded. No other write occurs.
- R5: A commit with at least one loaded byte raises busy_o on the next clock. busy_o then stays high for exactly WR_CYCLES clocks.
- R6: A commit with no loaded bytes does not raise busy_o and produces no writes.
- R7: sess_drop_i discards the open session. A following commit produces no busy and no writes.
- R8: While busy_o is high, session opens, byte loads and commits are ignored. They leave no session open and no bytes pending afterwards.
- R9: Byte loads while no session is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sess_open_i | input | 1 | Opens a session: latches page and start offset, clears the mask |
| sess_page_i | input | 7 | Page number of the session |
| sess_offs_i | input | 5 | Starting byte offset within the page |
| byte_load_i | input | 1 | Strobe: one data byte for the current offset |
| byte_data_i | input | 8 | Data byte accompanying byte_load_i |
| sess_drop_i | input | 1 | Abort or write-protect reject: discard the session |
| commit_i | input | 1 | STOP seen: commit the loaded bytes |
| busy_o | output | 1 | Write cycle in progress; engine must not acknowledge |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 12 | Array byte address {page, offset} |
| mem_wdata_o | output | 8 | Array write data |

## Verification
If a mask bit is stuck or lost, the write port emits an extra or missing byte within the first 32 busy cycles of that commit. The scoreboard checks address, data and busy-cycle slot on every write, so this shows up at once. A wrong offset cursor or a broken wrap moves or duplicates bytes, and the slot and address compare reveals it in the same window. A timer fault shows as a busy window whose length differs from WR_CYCLES, or as busy raised for an empty commit. A leak of session state across busy or a drop shows only on the next commit, as unexpected writes, so those cases end with a deliberate empty commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_PAGE_BYTES = 32;
  localparam int unsigned PWB_NUM_PAGES  = 128;
  localparam int unsigned PWB_DATA_W     = 8;
  // 4 ms at 250 MHz
  localparam int unsigned PWB_WR_CYCLES  = 1_000_000;
endpackage

// File: rtl/pwb_cursor.sv
module pwb_cursor #(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned PAGE_AW    = 7,
  parameter int unsigned OFFS_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               open_i,
  input  logic               close_i,
  input  logic               adv_i,
  input  logic [PAGE_AW-1:0] page_i,
  input  logic [OFFS_W-1:0]  offs_i,
  output logic               active_o,
  output logic [PAGE_AW-1:0] page_o,
  output logic [OFFS_W-1:0]  offs_o
);
  localparam logic [OFFS_W-1:0] LastOffs = OFFS_W'(PAGE_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      page_o   <= '0;
      offs_o   <= '0;
    end else if (close_i) begin
      active_o <= 1'b0;
    end else if (open_i) begin
      active_o <= 1'b1;
      page_o   <= page_i;
      offs_o   <= offs_i;
    end else if (adv_i) begin
      offs_o <= (offs_o == LastOffs) ? '0 : offs_o + 1'b1;
    end
  end

  // R3
  offs_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !open_i && !close_i && offs_o == LastOffs |=> offs_o == '0);
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OFFS_W     = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                clr_i,
  input  logic                                wr_en_i,
  input  logic [OFFS_W-1:0]                   wr_idx_i,
  input  logic [DATA_W-1:0]                   wr_data_i,
  output logic [PAGE_BYTES-1:0]               mask_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]   data_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == OFFS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mask_o[g] <= 1'b0;
      else if (clr_i)    mask_o[g] <= 1'b0;
      else if (hit)      mask_o[g] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       data_o[g] <= '0;
      else if (hit)      data_o[g] <= wr_data_i;
    end
  end

  // R3
  slot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !clr_i |=> mask_o[$past(wr_idx_i)] && data_o[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned WR_CYCLES  = 1_000_000,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned OFFS_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              scan_vld_o,
  output logic [OFFS_W-1:0] scan_idx_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] ScanEnd = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LastCnt) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o     = busy_o && (cnt_q == LastCnt);
  assign scan_vld_o = busy_o && (cnt_q < ScanEnd);
  assign scan_idx_o = OFFS_W'(cnt_q);

  // checker: busy window length
  logic [CNT_W:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (busy_o)  len_q <= len_q + 1'b1;
    else if (start_i) len_q <= '0;
  end

  // R5
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && cnt_q == '0);
  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> len_q == (CNT_W+1)'(WR_CYCLES));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int unsigned PAGE_BYTES = pwb_pkg::PWB_PAGE_BYTES,
  parameter int unsigned NUM_PAGES  = pwb_pkg::PWB_NUM_PAGES,
  parameter int unsigned DATA_W     = pwb_pkg::PWB_DATA_W,
  parameter int unsigned WR_CYCLES  = pwb_pkg::PWB_WR_CYCLES,
  localparam int unsigned OFFS_W    = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_AW   = $clog2(NUM_PAGES),
  localparam int unsigned ADDR_W    = PAGE_AW + OFFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sess_open_i,
  input  logic [PAGE_AW-1:0] sess_page_i,
  input  logic [OFFS_W-1:0]  sess_offs_i,
  input  logic               byte_load_i,
  input  logic [DATA_W-1:0]  byte_data_i,
  input  logic               sess_drop_i,
  input  logic               commit_i,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES);

  logic                              idle, active, has_data;
  logic                              open_go, close_go, load_go, start_go, clr_go;
  logic                              done, scan_vld;
  logic [OFFS_W-1:0]                 scan_idx, cur_offs;
  logic [PAGE_AW-1:0]                cur_page;
  logic [PAGE_BYTES-1:0]             mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] data;

  assign idle     = !busy_o;
  assign has_data = |mask;
  // priority: drop > commit > open > load
  assign close_go = idle && (sess_drop_i || commit_i);
  assign open_go  = idle && sess_open_i && !sess_drop_i && !commit_i;
  assign load_go  = idle && active && byte_load_i && !sess_open_i && !sess_drop_i && !commit_i;
  assign start_go = idle && commit_i && !sess_drop_i && has_data;
  assign clr_go   = (idle && (sess_drop_i || open_go || (commit_i && !has_data))) || done;

  pwb_cursor #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW), .OFFS_W(OFFS_W)
  ) i_cursor (
    .clk_i, .rst_ni,
    .open_i  (open_go),
    .close_i (close_go),
    .adv_i   (load_go),
    .page_i  (sess_page_i),
    .offs_i  (sess_offs_i),
    .active_o(active),
    .page_o  (cur_page),
    .offs_o  (cur_offs)
  );

  pwb_store #(
    .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .OFFS_W(OFFS_W)
  ) i_store (
    .clk_i, .rst_ni,
    .clr_i    (clr_go),
    .wr_en_i  (load_go),
    .wr_idx_i (cur_offs),
    .wr_data_i(byte_data_i),
    .mask_o   (mask),
    .data_o   (data)
  );

  pwb_timer #(
    .WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .OFFS_W(OFFS_W)
  ) i_timer (
    .clk_i, .rst_ni,
    .start_i   (start_go),
    .busy_o    (busy_o),
    .done_o    (done),
    .scan_vld_o(scan_vld),
    .scan_idx_o(scan_idx)
  );

  assign mem_we_o    = scan_vld && mask[scan_idx];
  assign mem_addr_o  = {cur_page, scan_idx};
  assign mem_wdata_o = data[scan_idx];

  // R6
  empty_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && idle && !sess_drop_i && !has_data |=> !busy_o);
  // R8
  frozen_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done |=> $stable(cur_page) && $stable(mask) && $stable(data) && !active);
  // R7
  drop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_drop_i && idle |=> !has_data && !active && !busy_o);
endmodule

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
  localparam int PB = 32, NP = 128, DW = 8, WC = 40;

  logic       clk, rst_n;
  logic       open_s, load_s, drop_s, commit_s;
  logic [6:0] page_s;
  logic [4:0] offs_s;
  logic [7:0] data_s;
  logic       busy, we;
  logic [11:0] addr;
  logic [7:0] wdata;

  page_write_buffer #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .DATA_W(DW), .WR_CYCLES(WC))
  i_page_write_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .sess_open_i(open_s), .sess_page_i(page_s), .sess_offs_i(offs_s),
    .byte_load_i(load_s), .byte_data_i(data_s),
    .sess_drop_i(drop_s), .commit_i(commit_s),
    .busy_o(busy), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { int addr; int data; int slot; } wr_t;
  wr_t exp_q[$];

  // reference model of the session
  bit      m_vld[PB];
  int      m_dat[PB];
  int      m_page, m_off;
  bit      m_act;

  task automatic m_clear();
    for (int i = 0; i < PB; i++) m_vld[i] = 0;
  endtask

  // monitor
  int bcyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected write at addr", int'(addr), -1);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(int'(addr) == e.addr, "R2", "write address", int'(addr), e.addr);
          check(int'(wdata) == e.data, "R3", "write data", int'(wdata), e.data);
          check(bcyc == e.slot, "R4", "write busy slot", bcyc, e.slot);
        end
      end
      if (busy) bcyc++;
      else bcyc = 0;
    end
  end

  task automatic t_open(int pg, int off);
    open_s = 1; page_s = 7'(pg); offs_s = 5'(off);
    @(negedge clk);
    open_s = 0;
    m_act = 1; m_page = pg; m_off = off; m_clear();
  endtask

  task automatic t_load(int d);
    load_s = 1; data_s = 8'(d);
    @(negedge clk);
    load_s = 0;
    if (m_act) begin
      m_vld[m_off] = 1; m_dat[m_off] = d; m_off = (m_off + 1) % PB;
    end
  endtask

  task automatic t_drop();
    drop_s = 1;
    @(negedge clk);
    drop_s = 0;
    m_act = 0; m_clear();
  endtask

  task automatic t_commit(string req, bit disturb);
    int n = 0, blen = 0;
    for (int o = 0; o < PB; o++)
      if (m_vld[o]) begin
        exp_q.push_back('{m_page * PB + o, m_dat[o], o});
        n++;
      end
    commit_s = 1;
    @(negedge clk);
    commit_s = 0;
    for (int i = 0; i < WC + 10; i++) begin
      if (disturb) begin
        if (i == 5) begin open_s = 1; page_s = 7'((m_page + 1) % NP); offs_s = 0; end
        if (i == 6) begin open_s = 0; load_s = 1; data_s = 8'h5A; end
        if (i == 7) begin load_s = 0; commit_s = 1; end
        if (i == 8) commit_s = 0;
      end
      if (busy) blen++;
      @(negedge clk);
    end
    check(blen == (n > 0 ? WC : 0), req, "busy length", blen, n > 0 ? WC : 0);
    check(exp_q.size() == 0, "R4", "writes still missing", exp_q.size(), 0);
    exp_q.delete();
    m_act = 0; m_clear();
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 100000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; open_s = 0; load_s = 0; drop_s = 0; commit_s = 0;
    page_s = 0; offs_s = 0; data_s = 0; m_act = 0; m_page = 0; m_off = 0;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(we == 0, "R1", "write enable after reset", we, 0);

    // R9: loads with no session, then commit does nothing
    t_load(8'h11); t_load(8'h22);
    t_commit("R9", 0);

    // R2: short session mid-page
    t_open(5, 7);
    t_load(8'hA1); t_load(8'hA2); t_load(8'hA3);
    t_commit("R5", 0);

    // R3: wrap from offset 30, 34 bytes overwrite offsets 30 and 31
    t_open(9, 30);
    for (int i = 0; i < 34; i++) t_load(i + 1);
    t_commit("R3", 0);

    // R2 boundary: last byte of last page
    t_open(127, 31);
    t_load(8'hEE);
    t_commit("R2", 0);

    // R4: sparse session, scattered by reopen
    t_open(0, 0);
    t_load(8'h01);
    t_open(0, 16);
    t_load(8'h10); t_load(8'h20);
    t_commit("R4", 0);

    // R6: address-only session
    t_open(3, 0);
    t_commit("R6", 0);

    // R7: dropped session, then loads after the drop
    t_open(4, 2);
    t_load(8'h33); t_load(8'h44);
    t_drop();
    t_load(8'h55);
    t_commit("R7", 0);

    // R8: open/load/commit during busy are ignored
    t_open(10, 0);
    t_load(8'h77); t_load(8'h88);
    t_commit("R8", 1);
    t_commit("R8", 0);

    // new session right after a write cycle
    t_open(11, 16);
    t_load(8'h99);
    t_commit("R5", 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule